// File: doc/BRIEF.md
# Toggle-Based Pulse Synchronizer

This block carries single-cycle event strobes from one clock domain into another clock domain that has no fixed relation to it. On the source side, every strobe flips a one-bit level register, so an event is carried as a change of level and not as a short pulse that the other clock might miss. On the destination side, that level passes through a chain of flip-flops on the destination clock. The first flop contains metastability. A registered XOR of two adjacent chain stages then recreates exactly one destination-clock-wide strobe for each level change.

A parameter sets the depth of the resynchronizing chain. A second parameter appends one more destination flop, so that both XOR inputs are taken past the first, possibly metastable, flop. This costs one extra cycle of latency. The source and destination clocks may be in either speed relation. Successive source strobes must be at least three destination periods apart. Strobes spaced more closely can merge or cancel, and that case is outside the block's contract.

Top module: `toggle_pulse_sync`

## Requirements
- R1: While `dstRstN` is low, `dstPulse` is 0. After both resets are released with no source strobe, `dstPulse` stays 0.
- R2: A source rising edge with `srcPulse` low leaves the source level unchanged. An idle source therefore produces no destination strobe, however long it stays idle.
- R3: Each source rising edge that samples `srcPulse` high produces exactly one destination strobe, high for exactly one destination cycle, provided strobes are at least three destination periods apart.
- R4: With `EXTRA_STAGE` = 0, `dstPulse` goes high after the `SYNC_STAGES`-th destination rising edge that follows the source edge taking the strobe. In zero-delay simulation this count is exact. In silicon, metastability may add one edge.
- R5: R3 and R4 hold for a source clock faster than, slower than, or close to the destination clock.
- R6: With `EXTRA_STAGE` = 1, the strobe for the same event rises exactly one destination cycle later than with `EXTRA_STAGE` = 0.
- R7: Both resets are asynchronous and active low. Pulling `dstRstN` low forces `dstPulse` to 0 without waiting for a destination clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| srcPulse | input | 1 | Event strobe, one source cycle wide |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| dstPulse | output | 1 | Recreated event strobe, one destination cycle wide |

## Verification
The bench counts destination rising edges and records that count at the source edge that samples each strobe. The default output must then be high at the falling edge that follows the edge whose count is `SYNC_STAGES` greater. The extra-stage variant must rise exactly one edge after that. The monitor samples on falling destination edges. Source rising edges are placed on half-nanosecond offsets and destination edges on whole nanoseconds, so the two never coincide and each expected edge is unambiguous. A width check is made on the falling edge after every rise, and strobe counts are compared at the end of each clock-ratio phase.

// File: rtl/pulse_sync_pkg.sv
`timescale 1ns/1ps
package pulse_sync_pkg;

  // Two adjacent destination-chain levels handed to the edge detector
  typedef struct packed {
    logic lvlNew;  // younger stage
    logic lvlOld;  // one cycle older
  } tapPair_t;

  // Total destination flops: resync depth plus optional clean-leg stage
  function automatic int chainLen(int stages, bit extra);
    return stages + (extra ? 1 : 0);
  endfunction

endpackage

// File: rtl/psync_src_toggle.sv
`timescale 1ns/1ps
module psync_src_toggle (
  input  logic srcClk,
  input  logic srcRstN,
  input  logic srcPulse,
  output logic toggleQ
);

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)      toggleQ <= 1'b0;
    else if (srcPulse) toggleQ <= ~toggleQ;
  end

  // R3
  toggle_flip_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcPulse |=> (toggleQ != $past(toggleQ)));

  // R2
  toggle_hold_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !srcPulse |=> $stable(toggleQ));

endmodule

// File: rtl/psync_dst_chain.sv
`timescale 1ns/1ps
module psync_dst_chain
  import pulse_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,   // must be 2 or more
  parameter bit EXTRA_STAGE = 1'b0
) (
  input  logic     dstClk,
  input  logic     dstRstN,
  input  logic     asyncLevel,
  output tapPair_t taps
);

  localparam int LEN = chainLen(SYNC_STAGES, EXTRA_STAGE);

  logic [LEN-1:0] chainQ;

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge dstClk or negedge dstRstN) begin
        if (!dstRstN) chainQ[0] <= 1'b0;
        else          chainQ[0] <= asyncLevel;
      end
    end else begin : g_next
      always_ff @(posedge dstClk or negedge dstRstN) begin
        if (!dstRstN) chainQ[i] <= 1'b0;
        else          chainQ[i] <= chainQ[i-1];
      end

      // R4
      stage_shift_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
        chainQ[i] == $past(chainQ[i-1]));
    end
  end

  // The last two stages feed the detector; with the extra stage both lie past chainQ[0]
  assign taps.lvlNew = chainQ[LEN-2];
  assign taps.lvlOld = chainQ[LEN-1];

endmodule

// File: rtl/psync_dst_edge.sv
`timescale 1ns/1ps
module psync_dst_edge
  import pulse_sync_pkg::*;
(
  input  logic     dstClk,
  input  logic     dstRstN,
  input  tapPair_t taps,
  output logic     dstPulse
);

  // Registered XOR keeps the output free of glitches across the tap pair
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) dstPulse <= 1'b0;
    else          dstPulse <= taps.lvlNew ^ taps.lvlOld;
  end

  // R3
  pulse_width_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstPulse |=> !dstPulse);

  // R3
  pulse_cause_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    $rose(dstPulse) |-> (taps.lvlOld != $past(taps.lvlOld)));

endmodule

// File: rtl/toggle_pulse_sync.sv
`timescale 1ns/1ps
module toggle_pulse_sync
  import pulse_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit EXTRA_STAGE = 1'b0
) (
  input  logic srcClk,
  input  logic srcRstN,
  input  logic srcPulse,
  input  logic dstClk,
  input  logic dstRstN,
  output logic dstPulse
);

  logic     toggleLvl;
  tapPair_t taps;

  psync_src_toggle u_src (
    .srcClk   (srcClk),
    .srcRstN  (srcRstN),
    .srcPulse (srcPulse),
    .toggleQ  (toggleLvl)
  );

  psync_dst_chain #(
    .SYNC_STAGES (SYNC_STAGES),
    .EXTRA_STAGE (EXTRA_STAGE)
  ) u_chain (
    .dstClk     (dstClk),
    .dstRstN    (dstRstN),
    .asyncLevel (toggleLvl),
    .taps       (taps)
  );

  psync_dst_edge u_edge (
    .dstClk   (dstClk),
    .dstRstN  (dstRstN),
    .taps     (taps),
    .dstPulse (dstPulse)
  );

endmodule

// File: tb/toggle_pulse_sync_tb.sv
`timescale 1ns/1ps
module toggle_pulse_sync_tb;

  localparam int STAGES = 2;

  logic srcClk = 1'b0, dstClk = 1'b0;
  logic srcRstN = 1'b0, dstRstN = 1'b0, srcPulse = 1'b0;
  logic dstPulse, dstPulseX;

  realtime srcHalf = 3.5;
  realtime halves[4] = '{3.5, 10.5, 26.5, 9.5};

  int checks = 0, failures = 0;
  int dstEdgeCnt = 0;
  int expQ[$];
  int riseQ[$];
  int sent = 0, seen = 0, seenX = 0;
  int popC, popR;
  bit prevHigh = 1'b0, prevHighX = 1'b0;
  bit inReset = 1'b1;

  toggle_pulse_sync #(.SYNC_STAGES(STAGES), .EXTRA_STAGE(1'b0)) u_dut (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcPulse(srcPulse),
    .dstClk(dstClk), .dstRstN(dstRstN), .dstPulse(dstPulse));

  toggle_pulse_sync #(.SYNC_STAGES(STAGES), .EXTRA_STAGE(1'b1)) u_dutExtra (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcPulse(srcPulse),
    .dstClk(dstClk), .dstRstN(dstRstN), .dstPulse(dstPulseX));

  // 50 MHz destination clock, rising edges on whole nanoseconds
  always #10 dstClk = ~dstClk;

  // Source rising edges always fall on half-nanosecond offsets
  initial begin
    #0.5;
    forever begin
      srcClk = 1'b1; #(srcHalf);
      srcClk = 1'b0; #(srcHalf);
    end
  end

  always @(posedge dstClk) dstEdgeCnt <= dstEdgeCnt + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one strobe, expected item = destination edge count at the sampling source edge
  task automatic sendPulse();
    @(negedge srcClk);
    srcPulse = 1'b1;
    @(posedge srcClk);
    expQ.push_back(dstEdgeCnt);
    sent++;
    @(negedge srcClk);
    srcPulse = 1'b0;
  endtask

  task automatic waitDst(int n);
    repeat (n) @(negedge dstClk);
  endtask

  // Monitor for the default instance
  always @(negedge dstClk) begin
    if (!inReset) begin
      if (prevHigh) check(!dstPulse, "R3", "default strobe width", dstPulse, 0);
      else if (dstPulse) begin
        seen++;
        if (expQ.size() == 0) check(1'b0, "R2", "strobe without source event", 1, 0);
        else begin
          popC = expQ.pop_front();
          check(dstEdgeCnt == popC + STAGES, "R4", "default latency edge", dstEdgeCnt, popC + STAGES);
          riseQ.push_back(dstEdgeCnt);
        end
      end
      prevHigh = dstPulse;
    end
  end

  // Monitor for the extra-stage instance
  always @(negedge dstClk) begin
    if (!inReset) begin
      if (prevHighX) check(!dstPulseX, "R3", "extra strobe width", dstPulseX, 0);
      else if (dstPulseX) begin
        seenX++;
        if (riseQ.size() == 0) check(1'b0, "R6", "extra strobe without default strobe", 1, 0);
        else begin
          popR = riseQ.pop_front();
          check(dstEdgeCnt == popR + 1, "R6", "extra stage offset", dstEdgeCnt, popR + 1);
        end
      end
      prevHighX = dstPulseX;
    end
  end

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    #5;
    check(dstPulse == 1'b0, "R1", "default output in reset", dstPulse, 0);
    check(dstPulseX == 1'b0, "R1", "extra output in reset", dstPulseX, 0);
    #40;
    srcRstN = 1'b1;
    dstRstN = 1'b1;
    inReset = 1'b0;
    waitDst(10);
    check(seen == 0, "R1", "strobes after reset release", seen, 0);
    check(dstPulse == 1'b0, "R1", "output idle after release", dstPulse, 0);

    // R5: several clock ratios, source faster, slower and near equal
    for (int p = 0; p < 4; p++) begin
      srcHalf = halves[p];
      repeat (3) @(posedge srcClk);
      for (int k = 0; k < 5; k++) begin
        sendPulse();
        waitDst(6);
      end
      waitDst(4);
      check(seen == sent, "R5", $sformatf("default count, half period %0.1f", halves[p]), seen, sent);
      check(seenX == sent, "R5", "extra-stage count", seenX, sent);
      sent = 0; seen = 0; seenX = 0;
    end

    // R2: long idle source yields no strobe
    waitDst(30);
    check(seen == 0, "R2", "default strobes while idle", seen, 0);
    check(seenX == 0, "R2", "extra strobes while idle", seenX, 0);

    // R7: asynchronous reset in the middle of a strobe
    srcHalf = 10.5;
    sendPulse();
    while (!dstPulse) @(negedge dstClk);
    #3;
    inReset = 1'b1;
    srcRstN = 1'b0;
    dstRstN = 1'b0;
    #1;
    check(dstPulse == 1'b0, "R7", "default output forced low", dstPulse, 0);
    check(dstPulseX == 1'b0, "R7", "extra output forced low", dstPulseX, 0);
    expQ.delete();
    riseQ.delete();
    sent = 0; seen = 0; seenX = 0;
    prevHigh = 1'b0; prevHighX = 1'b0;
    #40;
    srcRstN = 1'b1;
    dstRstN = 1'b1;
    inReset = 1'b0;
    waitDst(10);
    check(seen + seenX == 0, "R1", "no strobe after mid-run reset", seen + seenX, 0);

    // R3: exact one-for-one after recovery
    for (int k = 0; k < 3; k++) begin
      sendPulse();
      waitDst(6);
    end
    waitDst(4);
    check(seen == 3, "R3", "default count after recovery", seen, 3);
    check(seenX == 3, "R3", "extra count after recovery", seenX, 3);
    check(expQ.size() == 0, "R3", "unmatched source events", expQ.size(), 0);
    check(riseQ.size() == 0, "R6", "unmatched default strobes", riseQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule